// File: doc/BRIEF.md
# Latched Status Register with Interrupt

This block collects per-bit alarm and event conditions from a datapath, holds each one in a sticky latch, and shows them to a host through a two-step access. First the host writes a selection byte. Each bit written as 1 copies its current latched value into a readable snapshot, and each bit written as 0 leaves the snapshot as it was. A following read then clears the latches of the bits that were selected and seen set. An unlatched real-time copy of the conditions can be read at any time, with no selection step before it.

Each bit is typed by an input as either an alarm (a level condition) or an event. Alarm bits request an interrupt on every change of state. Event bits request one either on every cycle the event is present (continuous) or only on its first detection (one-shot). A one-shot bit re-arms once the condition has gone low. Pending requests are masked per bit and combined into an active-low interrupt line. The host reading a selected bit withdraws that bit's request.

Top module: `stsreg_latched`

## Requirements
- R1: A bit's latch sets in the cycle its condition input is high, and it holds 1 after the condition goes low until a clearing read. The snapshot bit i reports condition bit i.
- R2: A pulse on `host_wr_i` copies the latched value into `rd_data_o` for every bit where `host_wdata_i` is 1. Every bit where it is 0 keeps its previous `rd_data_o` value. The write also marks the bits written as 1 as selected.
- R3: A pulse on `host_rd_i` clears the latch of each bit that is selected and shows 1 in `rd_data_o`. It then drops all selections, so a second read with no new write clears nothing. Unselected bits are unaffected.
- R4: An alarm bit whose condition is still high at the clearing read stays latched.
- R5: A condition that is high in the same cycle as a clearing read wins, so the bit stays latched.
- R6: For a bit with `alarm_kind_i` = 1, both a rise and a fall of the condition raise that bit's interrupt request.
- R7: For an event bit (`alarm_kind_i` = 0) with `one_shot_i` = 0, every cycle the condition is high raises the request. While the condition stays high, the request survives a read.
- R8: For an event bit with `one_shot_i` = 1, only a rising edge of the condition raises the request. After a read releases it, it stays released while the condition is held, and it is raised again on the next rise.
- R9: A read with the bit selected releases that bit's request even if the alarm is still present.
- R10: `irq_n_o` is 0 exactly when some pending request has its `irq_mask_i` bit at 1. A request whose mask bit is 0 stays pending without driving the line.
- R11: `rt_status_o` shows the condition inputs one cycle later, with no write needed.
- R12: Reset clears the latches, the snapshot, the selections and the requests, and it drives `irq_n_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | WIDTH | Per-bit condition from the datapath |
| alarm_kind_i | input | WIDTH | 1 = alarm bit, 0 = event bit |
| one_shot_i | input | WIDTH | For event bits: 1 = interrupt only on first detection |
| irq_mask_i | input | WIDTH | 1 = bit may drive the interrupt |
| host_wr_i | input | 1 | Selection write strobe |
| host_wdata_i | input | WIDTH | Selection byte |
| host_rd_i | input | 1 | Clearing read strobe |
| rd_data_o | output | WIDTH | Readable snapshot |
| rt_status_o | output | WIDTH | Unlatched real-time conditions |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: eight bits and the combinational interrupt variant (`IRQ_REG` = 0). With those values, a change of `irq_mask_i` shows on `irq_n_o` at once, so the bench can prove that a masked request is still held by unmasking it between clock edges. Eight bits are enough to give each scenario a bit of its own: event, alarm, continuous and one-shot. This lets one flush between tasks reset every kind together.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;
   localparam int unsigned STS_MAX_WIDTH = 32;

   typedef enum logic {KIND_EVENT = 1'b0, KIND_ALARM = 1'b1} bit_kind_e;

   // Selects which condition activity raises a bit's interrupt request.
   function automatic logic irq_trigger(input bit_kind_e kind, input logic once,
                                        input logic cond, input logic rise,
                                        input logic change);
      if (kind == KIND_ALARM) return change;
      else if (once)          return rise;
      else                    return cond;
   endfunction
endpackage

// File: rtl/stsreg_edge.sv
module stsreg_edge #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cond_i,
   output logic [WIDTH-1:0] cond_q_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] change_o
);
   logic [WIDTH-1:0] cond_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cond_q <= '0;
      else        cond_q <= cond_i;
   end

   assign cond_q_o = cond_q;
   assign rise_o   = cond_i & ~cond_q;
   assign change_o = cond_i ^ cond_q;
endmodule

// File: rtl/stsreg_cell.sv
module stsreg_cell
   import stsreg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cond_i,
   input  logic rise_i,
   input  logic change_i,
   input  logic alarm_i,
   input  logic once_i,
   input  logic clr_lat_i,
   input  logic clr_pend_i,
   output logic lat_o,
   output logic pend_o
);
   logic lat_q, pend_q, trig;

   assign trig = irq_trigger(bit_kind_e'(alarm_i), once_i, cond_i, rise_i, change_i);

   // A set in the same cycle as a clear takes priority.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         lat_q  <= cond_i | (lat_q & ~clr_lat_i);
         pend_q <= trig | (pend_q & ~clr_pend_i);
      end
   end

   assign lat_o  = lat_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/stsreg_snapshot.sv
module stsreg_snapshot #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wmask_i,
   input  logic             rd_i,
   input  logic [WIDTH-1:0] lat_i,
   output logic [WIDTH-1:0] snap_o,
   output logic [WIDTH-1:0] sel_o,
   output logic [WIDTH-1:0] clr_lat_o,
   output logic [WIDTH-1:0] clr_pend_o
);
   logic [WIDTH-1:0] snap_q, sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q <= '0;
         sel_q  <= '0;
      end else if (wr_i) begin
         snap_q <= (wmask_i & lat_i) | (~wmask_i & snap_q);
         sel_q  <= wmask_i;
      end else if (rd_i) begin
         sel_q  <= '0;
      end
   end

   assign snap_o     = snap_q;
   assign sel_o      = sel_q;
   assign clr_lat_o  = rd_i ? (sel_q & snap_q) : '0;
   assign clr_pend_o = rd_i ? sel_q : '0;
endmodule

// File: rtl/stsreg_latched.sv
module stsreg_latched
   import stsreg_pkg::*;
#(
   parameter int unsigned WIDTH   = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cond_i,
   input  logic [WIDTH-1:0] alarm_kind_i,
   input  logic [WIDTH-1:0] one_shot_i,
   input  logic [WIDTH-1:0] irq_mask_i,
   input  logic             host_wr_i,
   input  logic [WIDTH-1:0] host_wdata_i,
   input  logic             host_rd_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic [WIDTH-1:0] rt_status_o,
   output logic             irq_n_o
);
   if (WIDTH < 1 || WIDTH > STS_MAX_WIDTH) begin : g_bad_width
      $error("stsreg_latched: WIDTH out of range");
   end

   logic [WIDTH-1:0] rise, change, lat_q, pend_q, sel_q, clr_lat, clr_pend;

   stsreg_edge #(.WIDTH(WIDTH)) u_edge (
      .clk(clk), .rst_n(rst_n), .cond_i(cond_i),
      .cond_q_o(rt_status_o), .rise_o(rise), .change_o(change)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      stsreg_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .cond_i(cond_i[i]), .rise_i(rise[i]), .change_i(change[i]),
         .alarm_i(alarm_kind_i[i]), .once_i(one_shot_i[i]),
         .clr_lat_i(clr_lat[i]), .clr_pend_i(clr_pend[i]),
         .lat_o(lat_q[i]), .pend_o(pend_q[i])
      );
   end

   stsreg_snapshot #(.WIDTH(WIDTH)) u_snap (
      .clk(clk), .rst_n(rst_n),
      .wr_i(host_wr_i), .wmask_i(host_wdata_i), .rd_i(host_rd_i),
      .lat_i(lat_q), .snap_o(rd_data_o), .sel_o(sel_q),
      .clr_lat_o(clr_lat), .clr_pend_o(clr_pend)
   );

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b1;
         else        irq_q <= ~|(((pend_q & ~clr_pend) | (alarm_kind_i & change)
                                  | (~alarm_kind_i & one_shot_i & rise)
                                  | (~alarm_kind_i & ~one_shot_i & cond_i)) & irq_mask_i);
      end
      assign irq_n_o = irq_q;
   end else begin : g_irq_comb
      assign irq_n_o = ~|(pend_q & irq_mask_i);
   end
endmodule

// File: rtl/stsreg_chk.sv
module stsreg_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] cond_i,
   input logic [WIDTH-1:0] alarm_kind_i,
   input logic [WIDTH-1:0] irq_mask_i,
   input logic             host_wr_i,
   input logic [WIDTH-1:0] host_wdata_i,
   input logic             host_rd_i,
   input logic [WIDTH-1:0] rd_data_o,
   input logic [WIDTH-1:0] rt_status_o,
   input logic             irq_n_o,
   input logic [WIDTH-1:0] lat_q,
   input logic [WIDTH-1:0] sel_q
);
   assert_latch_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|cond_i) |=> ((($past(cond_i)) & ~lat_q) == '0));

   assert_snapshot_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_i |=> (rd_data_o == (($past(host_wdata_i) & $past(lat_q))
                                 | (~$past(host_wdata_i) & $past(rd_data_o)))));

   assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_i && !host_wr_i) |=> ((lat_q & $past(sel_q & rd_data_o & ~cond_i)) == '0));

   assert_alarm_edge_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(alarm_kind_i & (cond_i ^ rt_status_o) & irq_mask_i))
      |=> (!irq_n_o || (irq_mask_i != $past(irq_mask_i))));

   assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_mask_i == '0) && $stable(irq_mask_i)) |-> irq_n_o);
endmodule

bind stsreg_latched stsreg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .alarm_kind_i(alarm_kind_i),
   .irq_mask_i(irq_mask_i), .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
   .host_rd_i(host_rd_i), .rd_data_o(rd_data_o), .rt_status_o(rt_status_o),
   .irq_n_o(irq_n_o), .lat_q(lat_q), .sel_q(sel_q)
);

// File: tb/stsreg_latched_tb.sv
`timescale 1ns/1ps
module stsreg_latched_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cond = '0, kind = '0, once = '0, imask = '0, wdata = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] rdata, rt;
   logic       irq_n;
   int         n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   stsreg_latched u_dut (
      .clk(clk), .rst_n(rst_n), .cond_i(cond), .alarm_kind_i(kind),
      .one_shot_i(once), .irq_mask_i(imask), .host_wr_i(wr),
      .host_wdata_i(wdata), .host_rd_i(rd), .rd_data_o(rdata),
      .rt_status_o(rt), .irq_n_o(irq_n)
   );

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [7:0] m);
      wr = 1'b1; wdata = m; tick(); wr = 1'b0; wdata = '0;
   endtask

   task automatic hread();
      rd = 1'b1; tick(); rd = 1'b0;
   endtask

   task automatic flush();
      cond = '0; tick(); hwrite(8'hFF); hread();
   endtask

   task automatic t_reset();
      chk("R12 rd_data at reset", rdata, 8'h00);
      chk("R12 irq_n at reset", {7'd0, irq_n}, 8'h01);
      chk("R12 rt at reset", rt, 8'h00);
   endtask

   task automatic t_latch_select();
      cond = 8'h04; tick(); cond = 8'h00; tick(2);
      hwrite(8'hFF); chk("R1 event latched", rdata, 8'h04);
      cond = 8'h20; tick(); cond = 8'h00; tick();
      hwrite(8'h01); chk("R2 unselected bit keeps value", rdata, 8'h04);
      hwrite(8'h20); chk("R2 selected bit refreshed", rdata, 8'h24);
      hread();
      hwrite(8'hFF); chk("R3 only selected bit cleared", rdata, 8'h04);
      hread();
      hwrite(8'hFF); chk("R3 read cleared latch", rdata, 8'h00);
      hread();
      cond = 8'h02; tick(); cond = 8'h00; tick();
      hread();
      hwrite(8'hFF); chk("R3 second read clears nothing", rdata, 8'h02);
      hread();
   endtask

   task automatic t_alarm_hold();
      kind = 8'h08; cond = 8'h08; tick();
      hwrite(8'hFF); hread();
      hwrite(8'hFF); chk("R4 alarm held stays latched", rdata, 8'h08);
      cond = 8'h00; tick();
      hwrite(8'hFF); chk("R1 latch holds after alarm drops", rdata, 8'h08);
      hread(); hwrite(8'hFF); chk("R1 cleared after read", rdata, 8'h00);
      hread(); kind = 8'h00;
   endtask

   task automatic t_priority();
      cond = 8'h01; tick(); cond = 8'h00; tick();
      hwrite(8'h01);
      cond = 8'h01; rd = 1'b1; tick(); rd = 1'b0; cond = 8'h00; tick();
      hwrite(8'h01); chk("R5 same-cycle event wins", rdata, 8'h01);
      hread(); flush();
   endtask

   task automatic t_alarm_irq();
      imask = 8'hFF; kind = 8'h10;
      cond = 8'h10; tick(); chk("R6 alarm rise irq", {7'd0, irq_n}, 8'h00);
      hwrite(8'h10); hread(); chk("R9 release while alarm present", {7'd0, irq_n}, 8'h01);
      tick(3); chk("R6 no irq while alarm steady", {7'd0, irq_n}, 8'h01);
      cond = 8'h00; tick(); chk("R6 alarm fall irq", {7'd0, irq_n}, 8'h00);
      hwrite(8'h10); hread(); chk("R9 release after fall", {7'd0, irq_n}, 8'h01);
      flush(); kind = 8'h00;
   endtask

   task automatic t_continuous();
      once = 8'h00; cond = 8'h40; tick();
      chk("R7 continuous event irq", {7'd0, irq_n}, 8'h00);
      hwrite(8'h40); hread(); chk("R7 irq survives read while held", {7'd0, irq_n}, 8'h00);
      cond = 8'h00; tick(); hwrite(8'h40); hread();
      chk("R7 released after event stops", {7'd0, irq_n}, 8'h01);
      flush();
   endtask

   task automatic t_one_shot();
      once = 8'h80; cond = 8'h80; tick();
      chk("R8 one-shot first detection", {7'd0, irq_n}, 8'h00);
      hwrite(8'h80); hread(); tick(3);
      chk("R8 no repeat while held", {7'd0, irq_n}, 8'h01);
      cond = 8'h00; tick(); chk("R8 no irq on fall", {7'd0, irq_n}, 8'h01);
      cond = 8'h80; tick(); chk("R8 re-armed on next rise", {7'd0, irq_n}, 8'h00);
      flush(); once = 8'h00;
   endtask

   task automatic t_mask();
      imask = 8'h00; cond = 8'h01; tick(); cond = 8'h00; tick();
      chk("R10 masked bit quiet", {7'd0, irq_n}, 8'h01);
      imask = 8'h01; #1; chk("R10 unmasked pending drives", {7'd0, irq_n}, 8'h00);
      flush(); imask = 8'hFF;
      chk("R10 idle line high", {7'd0, irq_n}, 8'h01);
   endtask

   task automatic t_realtime();
      cond = 8'h5A; tick(); chk("R11 real-time follows", rt, 8'h5A);
      cond = 8'h00; tick(); chk("R11 real-time unlatched", rt, 8'h00);
      flush();
   endtask

   task automatic t_reset_mid();
      cond = 8'h33; tick(); cond = 8'h00;
      hwrite(8'hFF);
      rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
      chk("R12 reset clears snapshot", rdata, 8'h00);
      chk("R12 reset clears irq", {7'd0, irq_n}, 8'h01);
      hwrite(8'hFF); chk("R12 reset clears latches", rdata, 8'h00);
      hread();
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick(3); rst_n = 1'b1; tick();
      t_reset();
      t_latch_select();
      t_alarm_hold();
      t_priority();
      t_alarm_irq();
      t_continuous();
      t_one_shot();
      t_mask();
      t_realtime();
      t_reset_mid();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule